// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs one read or one write against a register inside an external Ethernet PHY over the two-wire management bus: a clock line it generates (MDC) and a bidirectional data line (MDIO), which it drives through a separate output-enable. Software first loads the 16-bit data register and then writes the control word. A control word with its busy bit set starts a transaction. The busy bit reads back as 1 until the frame on the wire has ended. After a read, the value returned by the PHY is in the data register.

The serial clock comes from the core clock through an even divider. A 3-bit range code in the control word selects the divider. A state machine sends every frame bit over five named states: IDLE, PREAMBLE, HEADER, TURNAROUND and DATA.

- IDLE goes to PREAMBLE when a control write with the busy bit set is accepted.
- PREAMBLE goes to HEADER after bit 31.
- HEADER goes to TURNAROUND after bit 45.
- TURNAROUND goes to DATA after bit 47.
- DATA goes back to IDLE after bit 63, and busy clears on that edge.

Each of these moves happens on the core clock edge where MDC falls.

Top module: `mdio_master`

## Requirements
- R1: Writing the control word (`reg_sel`=1) with bit 0 (busy) set while idle starts a transaction. Bit 0 reads back as 1 until the end of the frame. The frame lasts exactly 64 MDC periods, so busy clears 64×N core cycles after the write edge, where N is the divide ratio. MDC makes exactly 64 rising edges in that time.
- R2: Control bits 4:2 select N as follows: 0 gives 16, 1 gives 26, 2 gives 42, 3 gives 62, and 4 to 7 give 102. Every MDC period is N core cycles, and MDC is high for N/2 of them.
- R3: The frame is sent MSB first, in this order: 32 ones, then the start code 01, then the opcode (01 for a write, 10 for a read), then the PHY address from control bits 15:11, then the register number from control bits 10:6, then the turnaround field, then 16 data bits.
- R4: Control bit 1 set selects a write. The turnaround field is driven as 10, and the data field is the data register. The output enable stays high for all 64 bits.
- R5: Control bit 1 clear selects a read. The output enable is low from bit 46 through bit 63. MDIO is sampled on each rising MDC of bits 48 to 63. When busy clears, the data register holds those 16 sampled bits.
- R6: MDIO and its enable change only on the core edge where MDC falls, or at launch. They never change while MDC is high.
- R7: While busy is set, writes to both the control word and the data register are ignored. This holds for their stored values and for the frame on the wire.
- R8: After reset, both registers read 0, and MDC and the output enable are low. Whenever the block is idle, MDC and the output enable stay low.
- R9: A control write with bit 0 clear stores the fields but starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 1 selects the control word, 0 selects the data register |
| reg_wdata | input | 16 | Write value |
| ctrl_q | output | 16 | Control word readback (bit 0 is busy) |
| data_q | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
Each result has a fixed due time.

- Busy falls at the 64×N-th core edge after the edge that took the control write.
- MDC rises N/2 edges into each bit, and falls N edges into each bit.
- Read data is loaded on the same edge that clears busy.

The bench counts core cycles at falling clock edges from the write edge onward and compares the count with 64×N. It records MDIO and its enable on each observed MDC rise, and it changes its PHY model's reply only on observed MDC falls. As a result, every comparison lands half a bit period away from any edge where the design changes these signals.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int RANGE_W    = 3;
    localparam int RATIO_W    = 7;
    localparam int FRAME_LEN  = 64;
    localparam int IDX_W      = $clog2(FRAME_LEN);

    localparam int PRE_LAST   = 31;
    localparam int HEAD_LAST  = 45;
    localparam int TURN_LAST  = 47;
    localparam int FRAME_LAST = FRAME_LEN - 1;

    localparam int BUSY_BIT   = 0;
    localparam int WRITE_BIT  = 1;
    localparam int RANGE_LO   = 2;
    localparam int REG_LO     = 6;
    localparam int PHY_LO     = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HEAD,
        ST_TURN,
        ST_DATA
    } mdio_state_t;

    function automatic logic [RATIO_W-1:0] mdc_ratio(input logic [RANGE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        unique case (code)
            3'd0:    r = RATIO_W'(16);
            3'd1:    r = RATIO_W'(26);
            3'd2:    r = RATIO_W'(42);
            3'd3:    r = RATIO_W'(62);
            default: r = RATIO_W'(102);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] div,
    output logic             mdc,
    output logic             rise_ev,
    output logic             fall_ev
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;

    always_comb begin
        half    = div >> 1;
        rise_ev = run && (cnt == half - CNT_W'(1));
        fall_ev = run && (cnt == div - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (start || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (fall_ev) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + CNT_W'(1);
            if (rise_ev) mdc <= 1'b1;
        end
    end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              st_write,
    input  logic [ADDR_W-1:0] st_phy,
    input  logic [ADDR_W-1:0] st_reg,
    input  logic [DATA_W-1:0] st_wdata,
    input  logic              cur_write,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              mdio_i,
    output logic              run,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe,
    output mdio_state_t       state
);
    mdio_state_t              state_nx;
    logic [IDX_W-1:0]         idx;
    logic [FRAME_LEN-1:0]     tx_sr;
    logic [DATA_W-1:0]        rx_sr;
    logic [FRAME_LEN-1:0]     frame;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions, all taken at the end of a bit
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_PRE;
            ST_PRE:  if (fall_ev && idx == IDX_W'(PRE_LAST))   state_nx = ST_HEAD;
            ST_HEAD: if (fall_ev && idx == IDX_W'(HEAD_LAST))  state_nx = ST_TURN;
            ST_TURN: if (fall_ev && idx == IDX_W'(TURN_LAST))  state_nx = ST_DATA;
            ST_DATA: if (fall_ev && idx == IDX_W'(FRAME_LAST)) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        frame = {{32{1'b1}}, 2'b01,
                 st_write ? 2'b01 : 2'b10,
                 st_phy, st_reg,
                 st_write ? 2'b10 : 2'b11,
                 st_write ? st_wdata : {DATA_W{1'b1}}};
        run   = (state != ST_IDLE);
        done  = (state == ST_DATA) && fall_ev && (idx == IDX_W'(FRAME_LAST));
        rdata = rx_sr;
    end

    // outputs: bit shifter, enable, read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            mdio_oe <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                idx     <= '0;
                tx_sr   <= frame;
                mdio_oe <= 1'b1;
            end
        end else begin
            if (fall_ev) begin
                idx   <= idx + IDX_W'(1);
                tx_sr <= tx_sr << 1;
                if (state == ST_HEAD && idx == IDX_W'(HEAD_LAST) && !cur_write)
                    mdio_oe <= 1'b0;
                if (done)
                    mdio_oe <= 1'b0;
            end
            if (rise_ev && state == ST_DATA)
                rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
        end
    end

    assign mdio_o = tx_sr[FRAME_LEN-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] data_q,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic [DATA_W-1:0]  ctrl_r;
    logic [DATA_W-1:0]  data_r;
    logic               busy;
    logic               accept;
    logic               start;
    logic               run;
    logic               done;
    logic               rise_ev;
    logic               fall_ev;
    logic [DATA_W-1:0]  rdata;
    logic [RATIO_W-1:0] div;
    mdio_state_t        seq_state;

    always_comb begin
        busy   = ctrl_r[BUSY_BIT];
        accept = reg_wr && !busy;
        start  = accept && reg_sel && reg_wdata[BUSY_BIT];
        div    = mdc_ratio(ctrl_r[RANGE_LO +: RANGE_W]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_r <= '0;
            data_r <= '0;
        end else begin
            if (accept) begin
                if (reg_sel) ctrl_r <= reg_wdata;
                else         data_r <= reg_wdata;
            end
            if (done) begin
                ctrl_r[BUSY_BIT] <= 1'b0;
                if (!ctrl_r[WRITE_BIT]) data_r <= rdata;
            end
        end
    end

    mdio_mdc_gen #(.CNT_W(RATIO_W)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (run),
        .div     (div),
        .mdc     (mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mdio_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .st_write  (reg_wdata[WRITE_BIT]),
        .st_phy    (reg_wdata[PHY_LO +: ADDR_W]),
        .st_reg    (reg_wdata[REG_LO +: ADDR_W]),
        .st_wdata  (data_r),
        .cur_write (ctrl_r[WRITE_BIT]),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .mdio_i    (mdio_i),
        .run       (run),
        .done      (done),
        .rdata     (rdata),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .state     (seq_state)
    );

    assign ctrl_q = ctrl_r;
    assign data_q = data_r;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ctrl,
    input logic [DATA_W-1:0] data,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input mdio_state_t       state
);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[BUSY_BIT] |-> (!mdc && !mdio_oe));

    assert_busy_ends_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl[BUSY_BIT]) |-> !mdc);

    assert_locked_regs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[BUSY_BIT] && $past(ctrl[BUSY_BIT])) |-> ($stable(ctrl[DATA_W-1:1]) && $stable(data)));

    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[WRITE_BIT] && (state == ST_TURN || state == ST_DATA)) |-> !mdio_oe);

    assert_write_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[WRITE_BIT] && ctrl[BUSY_BIT]) |-> mdio_oe);

    assert_still_while_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl_q),
    .data    (data_q),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .state   (seq_state)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] ctrl_q, data_q;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_in = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .data_q(data_q),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_in)
    );

    // PHY-side monitor and responder
    int   txn_id = 0, seen_id = 0;
    int   rises = 0, cyc = 0, last_rise = 0;
    int   per_min, per_max, hi_min, hi_max, hi_chg;
    logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;
    logic cap_o [64];
    logic cap_oe[64];
    logic [15:0] phy_val = '0;

    always @(negedge clk) begin
        if (seen_id != txn_id) begin
            seen_id = txn_id;
            rises = 0; per_min = 1000000; per_max = 0;
            hi_min = 1000000; hi_max = 0; hi_chg = 0;
        end
        cyc++;
        if (mdc && !prev_mdc) begin
            if (rises > 0) begin
                if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                if (cyc - last_rise > per_max) per_max = cyc - last_rise;
            end
            if (rises < 64) begin
                cap_o[rises]  = mdio_o;
                cap_oe[rises] = mdio_oe;
            end
            rises++;
            last_rise = cyc;
        end else if (mdc && prev_mdc) begin
            if (mdio_o !== prev_o || mdio_oe !== prev_oe) hi_chg++;
        end else if (!mdc && prev_mdc) begin
            if (cyc - last_rise < hi_min) hi_min = cyc - last_rise;
            if (cyc - last_rise > hi_max) hi_max = cyc - last_rise;
            mdio_in = (rises >= 48 && rises < 64) ? phy_val[15 - (rises - 48)] : 1'b1;
        end
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ratio(input int code);
        case (code)
            0: return 16;
            1: return 26;
            2: return 42;
            3: return 62;
            default: return 102;
        endcase
    endfunction

    function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, p, r,
                wr ? 2'b10 : 2'b11, wr ? d : 16'hFFFF};
    endfunction

    task automatic reg_write(input bit sel, input logic [15:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_txn(input int code, input bit wr, input logic [4:0] p,
                           input logic [4:0] r, input logic [15:0] wd,
                           input logic [15:0] rv, input bit poke);
        int n = ratio(code);
        int cycles = 0;
        logic [15:0] word = {p, r, 1'b0, 3'(code), wr, 1'b1};
        logic [63:0] ef = exp_frame(wr, p, r, wd);
        int bad_bits = 0, bad_oe = 0;
        phy_val = rv;
        reg_write(1'b0, wd);
        txn_id++;
        reg_write(1'b1, word);
        while (ctrl_q[0] === 1'b1 && cycles < 20000) begin
            if (poke && cycles == 100) begin
                reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = ~word;
            end else if (poke && cycles == 101) begin
                reg_sel = 1'b0; reg_wdata = ~wd;
            end else if (poke && cycles == 102) begin
                reg_wr = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        chk(cycles == 64 * n, "R1", "busy duration", cycles, 64 * n);
        chk(rises == 64, "R1", "MDC rising edges", rises, 64);
        chk(ctrl_q == (word & 16'hFFFE), "R7", "control readback", ctrl_q, word & 16'hFFFE);
        chk(per_min == n && per_max == n, "R2", "MDC period", per_max, n);
        chk(hi_min == n / 2 && hi_max == n / 2, "R2", "MDC high time", hi_max, n / 2);
        chk(hi_chg == 0, "R6", "MDIO changes while MDC high", hi_chg, 0);
        for (int i = 0; i < 64; i++) begin
            if (i < 46 || wr) if (cap_o[i] !== ef[63 - i]) bad_bits++;
            if (cap_oe[i] !== ((wr || i < 46) ? 1'b1 : 1'b0)) bad_oe++;
        end
        chk(bad_bits == 0, wr ? "R4" : "R3", "frame bit mismatches", bad_bits, 0);
        chk(bad_oe == 0, wr ? "R4" : "R5", "enable pattern mismatches", bad_oe, 0);
        if (wr) chk(data_q == wd, "R4", "data kept after write", data_q, wd);
        else    chk(data_q == rv, "R5", "read data", data_q, rv);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8", "idle lines", {mdc, mdio_oe}, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(ctrl_q == 0, "R8", "control after reset", ctrl_q, 0);
        chk(data_q == 0, "R8", "data after reset", data_q, 0);
        chk(mdc == 0 && mdio_oe == 0, "R8", "lines after reset", {mdc, mdio_oe}, 0);

        // R9: store without starting
        txn_id++;
        reg_write(1'b1, 16'hABCA);
        repeat (300) @(negedge clk);
        chk(ctrl_q == 16'hABCA, "R9", "fields stored", ctrl_q, 16'hABCA);
        chk(rises == 0, "R9", "no MDC activity", rises, 0);

        // sweep every range code, write and read
        for (int c = 0; c < 8; c++) begin
            run_txn(c, 1'b1, 5'(c * 3 + 1), 5'(31 - c * 2),
                    16'hA5C3 ^ 16'(c * 16'h1111), 16'h0, 1'b0);
            run_txn(c, 1'b0, 5'(30 - c), 5'(c * 4 + 2),
                    16'h0, 16'h8001 ^ 16'(c * 16'h0F0F), 1'b0);
        end

        // R7: writes while busy are ignored
        run_txn(0, 1'b1, 5'h15, 5'h0A, 16'h3C5A, 16'h0, 1'b1);
        run_txn(1, 1'b0, 5'h0B, 5'h11, 16'h0, 16'h6DB6, 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule